// File: doc/BRIEF.md
# SMBus Target Register File

This block is a bus target with a fixed 7-bit address. It holds a small bank of byte-wide registers and serves the usual SMBus transfers on them: send byte, receive byte, byte and word writes and reads, and block writes and reads. A system clock much faster than SCL oversamples SCL and SDA through a synchronizer. The block pulls SDA low through an open-drain enable and never drives it high. It does not stretch the clock and does not generate or check a packet error code.

The first byte written after the address is the command. Its low bits (`$clog2(NREGS)` of them) give the register index. Bit 7 picks block mode, and the bits between are ignored. The command stays in place across transfers, so every read starts at the register that the most recent command named. This holds whether the read follows a repeated start or is a bare receive byte in a later transfer. In block mode the first byte written after the command is a length, and a block read returns that length before the data. Register indices wrap modulo NREGS.

Top module: `smb_regfile_target`

## Requirements
- R1: After a start, the block ACKs the address byte (drives SDA low in the ninth clock) only when its upper 7 bits equal DEV_ADDR. Otherwise it NACKs and stays silent until the next start. Bit 0 of the address byte set to 1 selects a read.
- R2: In a write transfer, the first byte after the address is captured as the command. Bits [IW-1:0] give the register index and bit 7 selects block mode. A read that follows through a repeated start uses that command.
- R3: In non-block mode, each further written byte goes to consecutive registers starting at the index and wrapping modulo NREGS. A word write therefore stores its first (low) byte at the index and its second (high) byte at index+1.
- R4: A receive byte with no command in its own transfer returns the register named by the most recent command. Earlier reads do not move that starting point.
- R5: A non-block read returns the register at the index first and consecutive registers after it, so a word read yields the low byte and then the high byte.
- R6: In block mode, the first written byte after the command is a length, stored clamped to 32. Only that many following data bytes are stored. Bytes beyond the length are still ACKed but change no register.
- R7: A block read returns the stored length first, then that many registers from the index, then 0xFF (SDA released) for any further byte the host requests.
- R8: After the host NACKs a byte read from the block, the block does not pull SDA low until the next start.
- R9: A start or stop seen partway through a byte abandons that byte. A start returns the block to address matching with a cleared bit count, and a partly sent command byte is not captured.
- R10: After reset SDA is released, every register holds 0x00, the command is 0x00 and the stored block length is BLK_DEF.
- R11: The block changes its SDA drive only while SCL is low, so SDA is stable during every SCL high phase of a data or ACK bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A wrong command or pointer state shows up at the first byte the host reads back after the fault. The bench reads every register through word, block and bare receive transfers and compares each byte with its own model, so a corrupted index or a missed wrap shows within one transfer. A wrong block length shows in the count byte and in the first 0xFF position. A stuck bit counter or framing state shows as a missing or misplaced ACK on the very next address byte. That is why the bench interleaves aborted bytes, wrong addresses and host NACKs with normal traffic.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_RX, ST_ACK_W, ST_TX, ST_TX_ACK, ST_SKIP
  } st_e;

  // block length as stored: the host value capped at the limit
  function automatic logic [7:0] clamp_len(input logic [7:0] c, input logic [7:0] mx);
    return (c > mx) ? mx : c;
  endfunction

  // byte to shift out for read byte number n of a transfer
  function automatic logic [7:0] tx_pick(input logic blk, input logic [7:0] n,
                                         input logic [7:0] len, input logic [7:0] val);
    if (!blk)          return val;
    else if (n == 8'd0) return len;
    else if (n <= len) return val;
    else               return 8'hFF;
  endfunction

endpackage

// File: rtl/smb_linemon.sv
module smb_linemon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = ~scl_p & scl_s;
  assign scl_fall  = scl_p & ~scl_s;
  assign start_det = scl_p & scl_s & sda_p & ~sda_s;
  assign stop_det  = scl_p & scl_s & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int NREGS = 16,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[g] <= 8'h00;
      else if (we && (waddr == IW'(g)))    mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/smb_regfile_target.sv
module smb_regfile_target
  import smb_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         NREGS       = 16,
  parameter int         BLK_MAX     = 32,
  parameter int         BLK_DEF     = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int            IW  = $clog2(NREGS);
  localparam logic [IW-1:0] ONE = IW'(1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  smb_linemon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  st_e           state;
  logic [3:0]    nbit;
  logic [7:0]    rx_byte, txreg, blk_len, wr_n, rd_n;
  logic [IW-1:0] cmd_idx, ptr;
  logic          cmd_blk, is_rd, first_wr, cnt_due;
  logic [7:0]    rd_data;

  // named events shared with the checker
  logic byte_end, ev_addr_ack, ev_host_nack, wr_fire;
  logic [7:0] tx_next;
  logic tx_adv;

  assign byte_end     = scl_fall && (nbit == 4'd8);
  assign ev_addr_ack  = (state == ST_ADDR) && byte_end && (rx_byte[7:1] == DEV_ADDR);
  assign ev_host_nack = (state == ST_TX_ACK) && scl_rise && sda_s;
  assign wr_fire      = (state == ST_RX) && byte_end && !first_wr && !cnt_due &&
                        (!cmd_blk || (wr_n < blk_len));
  assign tx_next      = tx_pick(cmd_blk, rd_n, blk_len, rd_data);
  assign tx_adv       = !cmd_blk || ((rd_n != 8'd0) && (rd_n <= blk_len));

  smb_regbank #(.NREGS(NREGS), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(ptr), .wdata(rx_byte),
    .raddr(ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nbit     <= 4'd0;
      rx_byte  <= 8'h00;
      txreg    <= 8'hFF;
      blk_len  <= 8'(BLK_DEF);
      wr_n     <= 8'd0;
      rd_n     <= 8'd0;
      cmd_idx  <= '0;
      ptr      <= '0;
      cmd_blk  <= 1'b0;
      is_rd    <= 1'b0;
      first_wr <= 1'b0;
      cnt_due  <= 1'b0;
    end else if (start_det) begin
      state <= ST_ADDR;
      nbit  <= 4'd0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      nbit  <= 4'd0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            rx_byte <= {rx_byte[6:0], sda_s};
            nbit    <= nbit + 4'd1;
          end else if (byte_end) begin
            nbit <= 4'd0;
            if (state == ST_ADDR) begin
              if (ev_addr_ack) begin
                state    <= ST_ACK_A;
                is_rd    <= rx_byte[0];
                ptr      <= cmd_idx;
                rd_n     <= 8'd0;
                first_wr <= ~rx_byte[0];
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              state <= ST_ACK_W;
              if (first_wr) begin
                first_wr <= 1'b0;
                cmd_blk  <= rx_byte[7];
                cmd_idx  <= rx_byte[IW-1:0];
                ptr      <= rx_byte[IW-1:0];
                cnt_due  <= rx_byte[7];
                wr_n     <= 8'd0;
              end else if (cnt_due) begin
                cnt_due <= 1'b0;
                blk_len <= clamp_len(rx_byte, 8'(BLK_MAX));
              end else if (wr_fire) begin
                ptr <= ptr + ONE;
                if (cmd_blk) wr_n <= wr_n + 8'd1;
              end
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            if (is_rd) begin
              state <= ST_TX;
              txreg <= tx_next;
              rd_n  <= (rd_n == 8'hFF) ? rd_n : rd_n + 8'd1;
              if (tx_adv) ptr <= ptr + ONE;
            end else begin
              state <= ST_RX;
            end
          end
        end
        ST_ACK_W: if (scl_fall) state <= ST_RX;
        ST_TX: begin
          if (scl_rise) begin
            nbit <= nbit + 4'd1;
          end else if (scl_fall) begin
            if (nbit == 4'd8) begin
              state <= ST_TX_ACK;
              nbit  <= 4'd0;
            end else if (nbit != 4'd0) begin
              txreg <= {txreg[6:0], 1'b1};
            end
          end
        end
        ST_TX_ACK: begin
          if (ev_host_nack) begin
            state <= ST_SKIP;
          end else if (scl_fall) begin
            state <= ST_TX;
            txreg <= tx_next;
            rd_n  <= (rd_n == 8'hFF) ? rd_n : rd_n + 8'd1;
            if (tx_adv) ptr <= ptr + ONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = (state == ST_ACK_A) || (state == ST_ACK_W) ||
                  ((state == ST_TX) && !txreg[7]);
endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk
  import smb_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         BLK_MAX  = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_s,
  input logic       scl_rise,
  input logic       start_det,
  input logic       sda_oe,
  input st_e        state,
  input logic [3:0] nbit,
  input logic       ev_addr_ack,
  input logic       ev_host_nack,
  input logic [7:0] blk_len
);
  // independent capture of the bits since the last start
  logic [7:0] seen;
  logic [3:0] nrise;
  logic       nacked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 8'h00;
      nrise  <= 4'd0;
      nacked <= 1'b0;
    end else begin
      if (start_det) begin
        nrise <= 4'd0;
      end else if (scl_rise) begin
        seen  <= {seen[6:0], sda_s};
        nrise <= (nrise == 4'hF) ? nrise : nrise + 4'd1;
      end
      if (start_det)         nacked <= 1'b0;
      else if (ev_host_nack) nacked <= 1'b1;
    end
  end

  assert_addr_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_ack |-> (nrise == 4'd8 && seen[7:1] == DEV_ADDR));

  assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_len <= 8'(BLK_MAX));

  assert_quiet_after_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nacked |-> !sda_oe);

  assert_start_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && nbit == 4'd0));

  assert_no_drive_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> !$rose(sda_oe));
endmodule

bind smb_regfile_target smb_target_chk #(.DEV_ADDR(DEV_ADDR), .BLK_MAX(BLK_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
  .start_det(start_det), .sda_oe(sda_oe), .state(state), .nbit(nbit),
  .ev_addr_ack(ev_addr_ack), .ev_host_nack(ev_host_nack), .blk_len(blk_len)
);

// File: tb/test_smb_regfile_target.sv
module test_smb_regfile_target;
  localparam int         CLK_PERIOD = 10;
  localparam int         HP         = 8;
  localparam logic [6:0] ADDR       = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, host_low = 1'b0;
  logic sda_oe, sda_line;
  assign sda_line = ~(host_low | sda_oe);

  smb_regfile_target #(.DEV_ADDR(ADDR)) i_smb_regfile_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mreg [16];
  logic [7:0] mcmd = 8'h00, mlen = 8'd4;
  logic [7:0] wbuf [48];
  logic unstable = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic b);
    tick(3); host_low = ~b; tick(HP-3); scl = 1'b1; tick(HP); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    logic b1;
    tick(3); host_low = 1'b0; tick(HP-3); scl = 1'b1;
    tick(2); b1 = sda_line; tick(HP-4); b = sda_line;
    if (b1 !== b) unstable = 1'b1;
    tick(2); scl = 1'b0;
  endtask

  task automatic bus_start();
    host_low = 1'b0; tick(6); scl = 1'b1; tick(HP); host_low = 1'b1; tick(HP); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(3); host_low = 1'b1; tick(HP-3); scl = 1'b1; tick(HP); host_low = 1'b0; tick(HP);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic nack);
    logic x;
    b = 8'h00;
    unstable = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bit_in(x);
      b = {b[6:0], x};
    end
    chk("R11 sda stable while scl high", int'(unstable), 0);
    bit_out(nack);
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    int idx = int'(mcmd[3:0]);
    if (!mcmd[7])           return mreg[(idx + i) % 16];
    if (i == 0)             return mlen;
    if (i <= int'(mlen))    return mreg[(idx + i - 1) % 16];
    return 8'hFF;
  endfunction

  task automatic model_write(input int n);
    int idx = int'(wbuf[0][3:0]);
    mcmd = wbuf[0];
    if (!wbuf[0][7]) begin
      for (int i = 1; i < n; i++) mreg[(idx + i - 1) % 16] = wbuf[i];
    end else if (n > 1) begin
      mlen = (wbuf[1] > 8'd32) ? 8'd32 : wbuf[1];
      for (int i = 2; i < n; i++)
        if (i - 2 < int'(mlen)) mreg[(idx + i - 2) % 16] = wbuf[i];
    end
  endtask

  task automatic do_write(input int n, input string req);
    logic a;
    int nacks = 0;
    bus_start();
    wr_byte({ADDR, 1'b0}, a);
    chk({req, " address ack"}, int'(a), 0);
    for (int i = 0; i < n; i++) begin
      wr_byte(wbuf[i], a);
      if (a) nacks++;
    end
    chk({req, " data acks"}, nacks, 0);
    bus_stop();
    model_write(n);
  endtask

  task automatic do_read(input logic with_cmd, input logic [7:0] cmd, input int n,
                         input string req);
    logic a;
    logic [7:0] b;
    if (with_cmd) begin
      bus_start();
      wr_byte({ADDR, 1'b0}, a);
      wr_byte(cmd, a);
      mcmd = cmd;
    end
    bus_start();
    wr_byte({ADDR, 1'b1}, a);
    chk("R1 read address ack", int'(a), 0);
    for (int i = 0; i < n; i++) begin
      rd_byte(b, (i == n - 1));
      chk(req, int'(b), int'(exp_rd(i)));
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a, x;
    logic [7:0] b;
    int unsigned seed;
    for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
    seed = $urandom(32'd20240611);
    tick(5);
    chk("R10 sda released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(5);
    chk("R10 sda released after reset", int'(sda_oe), 0);

    // reset contents: bare read of register 0, default block length
    do_read(1'b0, 8'h00, 1, "R10 reset register");
    do_read(1'b1, 8'h80, 5, "R10 R7 default block read");

    // wrong address is NACKed and writes nothing
    bus_start();
    wr_byte({ADDR ^ 7'h01, 1'b0}, a);
    chk("R1 foreign address nack", int'(a), 1);
    wr_byte(8'h02, a);
    wr_byte(8'h55, a);
    bus_stop();
    do_read(1'b1, 8'h02, 1, "R1 foreign write ignored");

    // word write across the wrap point, word read back
    wbuf[0] = 8'h0F; wbuf[1] = 8'hA5; wbuf[2] = 8'h3C;
    do_write(3, "R3");
    do_read(1'b1, 8'h0F, 2, "R5 word read low then high");
    do_read(1'b1, 8'h00, 1, "R3 high byte wrapped to 0");
    do_read(1'b0, 8'h00, 1, "R4 bare receive");
    do_read(1'b0, 8'h00, 1, "R4 bare receive repeat");

    // block write with oversized length
    wbuf[0] = 8'h82; wbuf[1] = 8'd40; wbuf[2] = 8'h11; wbuf[3] = 8'h22; wbuf[4] = 8'h33;
    do_write(5, "R6");
    do_read(1'b1, 8'h82, 1, "R6 length clamped");

    // block write with extra bytes past the length
    wbuf[0] = 8'h84; wbuf[1] = 8'd2;
    wbuf[2] = 8'hD1; wbuf[3] = 8'hD2; wbuf[4] = 8'hD3; wbuf[5] = 8'hD4;
    do_write(6, "R6");
    do_read(1'b1, 8'h06, 1, "R6 bytes past length ignored");
    do_read(1'b1, 8'h84, 4, "R7 block read count data fill");

    // host NACK: target silent afterwards
    bus_start();
    wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'h00, a);
    mcmd = 8'h00;
    bus_start();
    wr_byte({ADDR, 1'b1}, a);
    rd_byte(b, 1'b1);
    chk("R8 byte before nack", int'(b), int'(exp_rd(0)));
    for (int i = 0; i < 9; i++) begin
      bit_in(x);
      chk("R8 line released after nack", int'(x), 1);
    end
    bus_stop();

    // stop in the middle of an address byte
    bus_start();
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    bus_stop();
    wbuf[0] = 8'h07; wbuf[1] = 8'h99;
    do_write(2, "R9 after aborted byte");

    // repeated start in the middle of a command byte
    bus_start();
    wr_byte({ADDR, 1'b0}, a);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b0);
    bus_start();
    wr_byte({ADDR, 1'b1}, a);
    chk("R9 address ack after restart", int'(a), 0);
    rd_byte(b, 1'b1);
    chk("R9 partial command not captured", int'(b), int'(exp_rd(0)));
    bus_stop();

    // random mix
    for (int t = 0; t < 40; t++) begin
      int op = int'($urandom % 4);
      int n;
      logic [7:0] cmd;
      case (op)
        0: begin
          wbuf[0] = {1'b0, 3'($urandom), 4'($urandom)};
          n = 1 + int'($urandom % 3);
          for (int i = 1; i < n; i++) wbuf[i] = 8'($urandom);
          do_write(n, "R2 R3");
        end
        1: begin
          int c = int'($urandom % 7);
          wbuf[0] = {1'b1, 3'($urandom), 4'($urandom)};
          wbuf[1] = 8'(c);
          n = 2 + c + int'($urandom % 2);
          for (int i = 2; i < n; i++) wbuf[i] = 8'($urandom);
          do_write(n, "R6");
        end
        2: begin
          cmd = 8'($urandom);
          if (cmd[7]) do_read(1'b1, cmd, int'(mlen) + 1, "R2 R7 block read");
          else        do_read(1'b1, cmd, 1 + int'($urandom % 2), "R2 R5 read");
        end
        default: begin
          n = mcmd[7] ? int'(mlen) + 1 : 1 + int'($urandom % 2);
          do_read(1'b0, mcmd, n, "R4 bare read");
        end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule